// File: doc/BRIEF.md
# Pipelined Per-Pair-Queued Crossbar Switch

The switch joins eight requesting agents to eight destination banks so that every requester can reach every bank. Each requester offers one transfer per cycle: a valid flag, a bank index and a payload. An accepted transfer is written into a small queue that belongs only to that requester/bank pair. One queue filling up never blocks the same requester's traffic to a different bank.

Every bank output has its own round-robin arbiter, which picks among the pair queues that point at that bank. The winner then travels through a fixed four-stage pipeline: request (queue write), arbitration (grant register), selection (payload multiplexed out of the granted queue) and transmission (output register with a valid/ready handshake). The outputs are independent of each other, so transfers to different banks move in the same cycles. Each delivered transfer carries the index of the requester it came from.

Top module: `xbar_switch`

## Requirements
- R1: Any source index 0..7 can reach any destination index 0..7. A delivered transfer carries the unchanged payload, and `dst_src` shows the index of the source that sent it.
- R2: Transfers accepted in the same cycle from different sources to different destinations are all presented at their outputs in the same later cycle.
- R3: Each source/destination pair queue holds at most 2 transfers. `src_ready[s]` is low while the queue for the destination currently on `src_dst` of source `s` holds 2 entries. A full queue toward one destination does not lower `src_ready` when the source selects a different destination.
- R4: A transfer into an idle pipeline is accepted on a rising edge. `dst_valid` for it rises after the third rising edge that follows the accepting edge.
- R5: Each destination grants in round-robin order. The search starts at the source index one above the last winner and wraps from 7 to 0, and the last winner after reset is source 7. A destination whose `dst_ready` stays high delivers one transfer per cycle while requests are waiting.
- R6: While `dst_valid` is high and `dst_ready` is low, the output keeps `dst_valid`, `dst_data` and `dst_src` unchanged, and no transfer is lost.
- R7: Transfers from one source to one destination are delivered in the order they were accepted.
- R8: While reset is held, all `dst_valid` bits are low and all `src_ready` bits are high on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| src_valid | input | 8 | Per-source request valid |
| src_dst | input | 24 | Per-source destination index, 3 bits per source, source s at bits [3s+2:3s] |
| src_data | input | 256 | Per-source payload, 32 bits per source, source s at bits [32s+31:32s] |
| src_ready | output | 8 | Per-source accept; a transfer moves when valid and ready are both high at an edge |
| dst_valid | output | 8 | Per-destination transfer valid |
| dst_data | output | 256 | Per-destination payload, 32 bits each |
| dst_src | output | 24 | Per-destination source index of the presented transfer, 3 bits each |
| dst_ready | input | 8 | Per-destination accept from the bank |

## Verification
Two kinds of fault would show at the ports. A corrupt queue pointer or count appears as a reordered, duplicated or missing payload at the destination, at the latest four edges after the entry concerned reaches the head of its queue. It can also appear as `src_ready` staying high past two entries, in the same cycle as the overfill. A stale round-robin pointer or a wrong grant mask appears as a wrong `dst_src` sequence, or as a bubble in `dst_valid` during a contended burst, on the very next delivery. The directed scenarios therefore check exact delivery cycles, exact source order and per-pair payload order, so that any such divergence is seen within a few cycles of the fault.

// File: rtl/xbar_pkg.sv
// Package: default sizing shared by the crossbar switch and its sub-blocks.
// Assumes: nothing; holds constants only.
package xbar_pkg;
    localparam int XB_NSRC   = 8;   // requesters
    localparam int XB_NDST   = 8;   // destination banks
    localparam int XB_DW     = 32;  // payload width
    localparam int XB_QDEPTH = 2;   // entries per source/destination queue
endpackage

// File: rtl/xbar_pair_fifo.sv
// Module: small FIFO owned by one source/destination pair.
// Holds up to DEPTH payloads and shows the head and the occupancy.
// Assumes: the writer never pushes when count_o == DEPTH, and the reader
// never pops when count_o == 0. The top module's ready and the grant
// logic guarantee both.
module xbar_pair_fifo #(
    parameter  int DW    = 32,
    parameter  int DEPTH = 2,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic [DW-1:0] head_o,
    output logic [CW-1:0] count_o
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    // Storage write on push; payload storage needs no reset.
    always_ff @(posedge clk) begin
        if (push_i) mem[wr_ptr] <= push_data_i;
    end

    // Pointer and occupancy bookkeeping with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_o <= '0;
        end else begin
            if (push_i) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_i)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count_o <= count_o + CW'(push_i) - CW'(pop_i);
        end
    end

    assign head_o = mem[rd_ptr];

endmodule

// File: rtl/xbar_rr_arbiter.sv
// Module: round-robin arbiter over N requests.
// Grants the first request found above the last winner, wrapping around.
// The winner is remembered only when take_i is high.
// Assumes: req_i is stable during the cycle; after reset the last winner
// is N-1, so index 0 has top priority.
module xbar_rr_arbiter #(
    parameter  int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    input  logic          take_i,
    output logic [N-1:0]  gnt_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);

    logic [IW-1:0] last_q;
    int            cand;

    // Search requests in rotating order starting after the last winner.
    always_comb begin
        gnt_o = '0;
        idx_o = '0;
        any_o = 1'b0;
        cand  = 0;
        for (int i = 1; i <= N; i++) begin
            cand = int'(last_q) + i;
            if (cand >= N) cand = cand - N;
            if (!any_o && req_i[cand]) begin
                any_o       = 1'b1;
                gnt_o[cand] = 1'b1;
                idx_o       = IW'(cand);
            end
        end
    end

    // Remember the winner when the grant is actually taken.
    always_ff @(posedge clk) begin
        if (!rst_n)              last_q <= IW'(N - 1);
        else if (take_i && any_o) last_q <= idx_o;
    end

endmodule

// File: rtl/xbar_out_port.sv
// Module: one destination output of the crossbar.
// Arbitrates among the pair queues aimed at this destination, registers the
// grant, selects the granted queue head (popping it), and holds the result
// in a transmit register with a valid/ready handshake.
// Assumes: queue counts and heads are registered values from pair FIFOs.
// A grant pending in the grant register refers to its queue's current head.
module xbar_out_port #(
    parameter  int NSRC  = 8,
    parameter  int DW    = 32,
    parameter  int DEPTH = 2,
    localparam int SIW   = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC*CW-1:0] q_count_i,
    input  logic [NSRC*DW-1:0] q_head_i,
    output logic [NSRC-1:0]    q_pop_o,
    output logic [NSRC-1:0]    gnt_o,
    output logic               dst_valid_o,
    output logic [DW-1:0]      dst_data_o,
    output logic [SIW-1:0]     dst_src_o,
    input  logic               dst_ready_i
);

    logic            g_vld, s_vld, t_vld;
    logic [SIW-1:0]  g_src, s_src, t_src;
    logic [DW-1:0]   s_data, t_data;
    logic            t_adv, s_adv, g_adv;
    logic [NSRC-1:0] elig;
    logic [SIW-1:0]  win;
    logic            win_any;
    logic [CW-1:0]   cnt_s;

    // Stage advance conditions, from the output back to the arbiter.
    assign t_adv = !t_vld || dst_ready_i;
    assign s_adv = !s_vld || t_adv;
    assign g_adv = !g_vld || s_adv;

    // A queue is eligible if it holds an entry not already pending in the grant stage.
    always_comb begin
        cnt_s = '0;
        for (int s = 0; s < NSRC; s++) begin
            cnt_s   = q_count_i[s*CW +: CW];
            elig[s] = (int'(cnt_s) > 1) ||
                      ((int'(cnt_s) == 1) && !(g_vld && (g_src == SIW'(s))));
        end
    end

    xbar_rr_arbiter #(.N(NSRC)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (elig),
        .take_i (g_adv),
        .gnt_o  (gnt_o),
        .idx_o  (win),
        .any_o  (win_any)
    );

    // Pop the granted queue when its head moves into the select stage.
    always_comb begin
        q_pop_o = '0;
        if (g_vld && s_adv) q_pop_o[g_src] = 1'b1;
    end

    // Arbitration stage: register the winning source index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_vld <= 1'b0;
            g_src <= '0;
        end else if (g_adv) begin
            g_vld <= win_any;
            g_src <= win;
        end
    end

    // Selection stage: multiplex the granted queue head into a register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_vld  <= 1'b0;
            s_src  <= '0;
            s_data <= '0;
        end else if (s_adv) begin
            s_vld  <= g_vld;
            s_src  <= g_src;
            s_data <= q_head_i[g_src*DW +: DW];
        end
    end

    // Transmission stage: hold the transfer until the destination accepts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_vld  <= 1'b0;
            t_src  <= '0;
            t_data <= '0;
        end else if (t_adv) begin
            t_vld  <= s_vld;
            t_src  <= s_src;
            t_data <= s_data;
        end
    end

    assign dst_valid_o = t_vld;
    assign dst_data_o  = t_data;
    assign dst_src_o   = t_src;

endmodule

// File: rtl/xbar_switch.sv
// Module: NSRC x NDST crossbar with one queue per source/destination pair and
// a four-stage request/arbitrate/select/transmit path per destination.
// Assumes: src_dst holds a legal destination index while src_valid is high;
// an index at or above NDST is never accepted.
module xbar_switch
    import xbar_pkg::*;
#(
    parameter  int NSRC   = XB_NSRC,
    parameter  int NDST   = XB_NDST,
    parameter  int DW     = XB_DW,
    parameter  int QDEPTH = XB_QDEPTH,
    localparam int SIW    = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int DIW    = (NDST > 1) ? $clog2(NDST) : 1,
    localparam int CW     = $clog2(QDEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:0]     src_valid,
    input  logic [NSRC*DIW-1:0] src_dst,
    input  logic [NSRC*DW-1:0]  src_data,
    output logic [NSRC-1:0]     src_ready,
    output logic [NDST-1:0]     dst_valid,
    output logic [NDST*DW-1:0]  dst_data,
    output logic [NDST*SIW-1:0] dst_src,
    input  logic [NDST-1:0]     dst_ready
);

    logic [CW-1:0]            q_cnt  [NSRC][NDST];
    logic [DW-1:0]            q_head [NSRC][NDST];
    logic [NSRC-1:0]          d_pop  [NDST];
    logic [NSRC*NDST*CW-1:0]  all_cnt;
    logic [NSRC*NDST-1:0]     all_pop;
    logic [NDST*NSRC-1:0]     all_gnt;

    // Source ready: room in the queue toward the destination it currently names.
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            src_ready[s] = 1'b0;
            for (int d = 0; d < NDST; d++) begin
                if (src_dst[s*DIW +: DIW] == DIW'(d))
                    src_ready[s] = (int'(q_cnt[s][d]) < QDEPTH);
            end
        end
    end

    // Request stage: one queue per source/destination pair.
    for (genvar gs = 0; gs < NSRC; gs++) begin : g_src
        for (genvar gd = 0; gd < NDST; gd++) begin : g_dst
            logic push;
            assign push = src_valid[gs] && src_ready[gs] &&
                          (src_dst[gs*DIW +: DIW] == DIW'(gd));

            xbar_pair_fifo #(.DW(DW), .DEPTH(QDEPTH)) u_q (
                .clk         (clk),
                .rst_n       (rst_n),
                .push_i      (push),
                .push_data_i (src_data[gs*DW +: DW]),
                .pop_i       (d_pop[gd][gs]),
                .head_o      (q_head[gs][gd]),
                .count_o     (q_cnt[gs][gd])
            );

            assign all_cnt[(gs*NDST+gd)*CW +: CW] = q_cnt[gs][gd];
            assign all_pop[gs*NDST+gd]            = d_pop[gd][gs];
        end
    end

    // Arbitration, selection and transmission: one output port per destination.
    for (genvar gd = 0; gd < NDST; gd++) begin : g_out
        logic [NSRC*CW-1:0] cnt_v;
        logic [NSRC*DW-1:0] head_v;

        for (genvar gs = 0; gs < NSRC; gs++) begin : g_gather
            assign cnt_v[gs*CW +: CW]  = q_cnt[gs][gd];
            assign head_v[gs*DW +: DW] = q_head[gs][gd];
        end

        xbar_out_port #(.NSRC(NSRC), .DW(DW), .DEPTH(QDEPTH)) u_port (
            .clk         (clk),
            .rst_n       (rst_n),
            .q_count_i   (cnt_v),
            .q_head_i    (head_v),
            .q_pop_o     (d_pop[gd]),
            .gnt_o       (all_gnt[gd*NSRC +: NSRC]),
            .dst_valid_o (dst_valid[gd]),
            .dst_data_o  (dst_data[gd*DW +: DW]),
            .dst_src_o   (dst_src[gd*SIW +: SIW]),
            .dst_ready_i (dst_ready[gd])
        );
    end

endmodule

// File: rtl/xbar_switch_chk.sv
// Module: property checker for the crossbar switch, attached by bind.
// Observes the ports plus the queue counts, pops and arbiter grants.
// Assumes: connected through the bind statement at the end of this file.
module xbar_switch_chk #(
    parameter int NSRC   = 8,
    parameter int NDST   = 8,
    parameter int DW     = 32,
    parameter int SIW    = 3,
    parameter int CW     = 2,
    parameter int QDEPTH = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NSRC-1:0]         src_ready,
    input logic [NDST-1:0]         dst_valid,
    input logic [NDST-1:0]         dst_ready,
    input logic [NDST*DW-1:0]      dst_data,
    input logic [NDST*SIW-1:0]     dst_src,
    input logic [NSRC*NDST*CW-1:0] all_cnt,
    input logic [NSRC*NDST-1:0]    all_pop,
    input logic [NDST*NSRC-1:0]    all_gnt
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (dst_valid == '0) && (src_ready == '1)); // R8

    for (genvar gd = 0; gd < NDST; gd++) begin : g_d
        AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            dst_valid[gd] && !dst_ready[gd] |=>
                dst_valid[gd] && $stable(dst_data[gd*DW +: DW]) &&
                $stable(dst_src[gd*SIW +: SIW])); // R6

        AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(all_gnt[gd*NSRC +: NSRC])); // R5
    end

    for (genvar gq = 0; gq < NSRC*NDST; gq++) begin : g_q
        AST_Q_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            int'(all_cnt[gq*CW +: CW]) <= QDEPTH); // R3

        AST_FULL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(all_cnt[gq*CW +: CW]) == QDEPTH) && !all_pop[gq] |=>
                int'(all_cnt[gq*CW +: CW]) == QDEPTH); // R3

        AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
            all_pop[gq] |-> all_cnt[gq*CW +: CW] != '0); // R7
    end

endmodule

bind xbar_switch xbar_switch_chk #(
    .NSRC(NSRC), .NDST(NDST), .DW(DW), .SIW(SIW), .CW(CW), .QDEPTH(QDEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_ready (src_ready),
    .dst_valid (dst_valid),
    .dst_ready (dst_ready),
    .dst_data  (dst_data),
    .dst_src   (dst_src),
    .all_cnt   (all_cnt),
    .all_pop   (all_pop),
    .all_gnt   (all_gnt)
);

// File: tb/tb_xbar_switch.sv
// Directed bench: one task per scenario, plus a per-pair scoreboard monitor.
module tb_xbar_switch;
    localparam int NS  = 8;
    localparam int ND  = 8;
    localparam int DW  = 32;
    localparam int SIW = 3;
    localparam int DIW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS-1:0]     src_valid = '0;
    logic [NS*DIW-1:0] src_dst = '0;
    logic [NS*DW-1:0]  src_data = '0;
    logic [NS-1:0]     src_ready;
    logic [ND-1:0]     dst_valid;
    logic [ND*DW-1:0]  dst_data;
    logic [ND*SIW-1:0] dst_src;
    logic [ND-1:0]     dst_ready = '1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [DW-1:0] sb [ND][NS][$];
    logic          prev_stall [ND];
    logic [DW-1:0] prev_data  [ND];

    always #5 clk = ~clk;

    xbar_switch dut (
        .clk(clk), .rst_n(rst_n),
        .src_valid(src_valid), .src_dst(src_dst), .src_data(src_data), .src_ready(src_ready),
        .dst_valid(dst_valid), .dst_data(dst_data), .dst_src(dst_src), .dst_ready(dst_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_src(input int s, input bit v, input int d, input logic [DW-1:0] data);
        src_valid[s]             = v;
        src_dst[s*DIW +: DIW]    = DIW'(d);
        src_data[s*DW +: DW]     = data;
    endtask

    // Scoreboard monitor: records accepts, checks per-pair order (R7) and output hold (R6).
    int            m_s;
    logic [DW-1:0] m_exp;
    always @(negedge clk) begin
        if (rst_n) begin
            for (int d = 0; d < ND; d++) begin
                if (prev_stall[d])
                    chk(dst_valid[d] && dst_data[d*DW +: DW] == prev_data[d], "R6",
                        "stalled output changed", dst_data[d*DW +: DW], prev_data[d]);
                if (dst_valid[d] && dst_ready[d]) begin
                    m_s = int'(dst_src[d*SIW +: SIW]);
                    if (sb[d][m_s].size() == 0) begin
                        chk(1'b0, "R1", "delivery with nothing outstanding", m_s, d);
                    end else begin
                        m_exp = sb[d][m_s].pop_front();
                        chk(dst_data[d*DW +: DW] == m_exp, "R7", "pair payload order",
                            dst_data[d*DW +: DW], m_exp);
                    end
                end
                prev_stall[d] = dst_valid[d] && !dst_ready[d];
                prev_data[d]  = dst_data[d*DW +: DW];
            end
            for (int s = 0; s < NS; s++)
                if (src_valid[s] && src_ready[s])
                    sb[int'(src_dst[s*DIW +: DIW])][s].push_back(src_data[s*DW +: DW]);
        end else begin
            for (int d = 0; d < ND; d++) prev_stall[d] = 1'b0;
        end
    end

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        @(negedge clk);
        chk(dst_valid == '0, "R8", "dst_valid in reset", dst_valid, 0);
        chk(src_ready == '1, "R8", "src_ready in reset", src_ready, 8'hff);
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_latency();
        set_src(3, 1'b1, 5, 32'hA5A5_0003);
        @(negedge clk);
        chk(src_ready[3], "R3", "ready with empty queue", src_ready[3], 1);
        tick();
        set_src(3, 1'b0, 0, '0);
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            chk(!dst_valid[5], "R4", "valid too early", k, 0);
        end
        @(negedge clk);
        chk(dst_valid[5], "R4", "valid after third edge", dst_valid[5], 1);
        chk(dst_src[5*SIW +: SIW] == 3'd3, "R1", "source index", dst_src[5*SIW +: SIW], 3);
        repeat (4) tick();
    endtask

    task automatic t_parallel();
        for (int s = 0; s < NS; s++) set_src(s, 1'b1, (s + 3) % ND, 32'h200 + s);
        tick();
        for (int s = 0; s < NS; s++) set_src(s, 1'b0, 0, '0);
        repeat (3) @(negedge clk);
        @(negedge clk);
        chk(dst_valid == '1, "R2", "all outputs in same cycle", dst_valid, 8'hff);
        for (int d = 0; d < ND; d++)
            chk(dst_src[d*SIW +: SIW] == SIW'((d + 5) % ND), "R1", "crossbar routing",
                dst_src[d*SIW +: SIW], (d + 5) % ND);
        repeat (4) tick();
    endtask

    task automatic t_rr(input logic [7:0] mask, input logic [31:0] ord, input int n);
        int waited;
        for (int s = 0; s < NS; s++)
            if (mask[s]) set_src(s, 1'b1, 2, 32'h300 + s);
        tick();
        for (int s = 0; s < NS; s++) set_src(s, 1'b0, 0, '0);
        waited = 0;
        @(negedge clk);
        while (!dst_valid[2] && waited < 10) begin
            @(negedge clk);
            waited++;
        end
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            chk(dst_valid[2], "R5", "one grant per cycle", dst_valid[2], 1);
            chk(dst_src[2*SIW +: SIW] == ord[k*4 +: 3], "R5", "round-robin order",
                dst_src[2*SIW +: SIW], ord[k*4 +: 3]);
        end
        repeat (4) tick();
    endtask

    task automatic t_full();
        int sent;
        sent = 0;
        dst_ready[4] = 1'b0;
        for (int c = 0; c < 10; c++) begin
            set_src(1, 1'b1, 4, 32'h400 + sent);
            @(negedge clk);
            if (src_ready[1]) sent++;
            tick();
        end
        chk(sent == 4, "R3", "accepted before stall", sent, 4);
        @(negedge clk);
        chk(!src_ready[1], "R3", "ready low when pair queue full", src_ready[1], 0);
        chk(dst_valid[4] && dst_data[4*DW +: DW] == 32'h400, "R6", "held first transfer",
            dst_data[4*DW +: DW], 32'h400);
        tick();
        set_src(1, 1'b1, 6, 32'h4FF);
        @(negedge clk);
        chk(src_ready[1], "R3", "other destination still open", src_ready[1], 1);
        tick();
        set_src(1, 1'b0, 0, '0);
        dst_ready[4] = 1'b1;
        repeat (10) tick();
        @(negedge clk);
        chk(!dst_valid[4], "R6", "stalled output drained", dst_valid[4], 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R1", "watchdog expired", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_parallel();
        t_rr(8'hff, 32'h7654_3210, 8);
        t_rr(8'h24, 32'h0000_0052, 2);
        t_rr(8'h49, 32'h0000_0306, 3);
        t_full();
        for (int d = 0; d < ND; d++)
            for (int s = 0; s < NS; s++)
                chk(sb[d][s].size() == 0, "R1", "transfer never delivered", sb[d][s].size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule